// File: doc/BRIEF.md
# Sector ID Field Checker

This block sits behind the byte deserialiser of a floppy disk controller. It examines the identification record that follows each ID address mark on the disk. A search begins with a one-cycle start strobe. From then on, every mark reported on `idMark` arms a capture of the next six stream bytes. These bytes are the track number, the side number, the sector number, the length code and two check bytes. A CRC-16 is computed over the implied sync/mark prefix and the whole record.

In seek mode the record is compared against the track and sector registers. The side byte is also compared when the command asks for a side check. A hit with a clean CRC ends the search and reports the sector length, both as a code and as a byte count. A hit with a corrupt CRC is flagged and the search goes on.

In read-address mode the six bytes are passed out unchanged, and the first record seen ends the search. Either way, a search that sees a set number of index pulses without finishing ends with a record-not-found result.

Top module: `idFieldChecker`

## Requirements
- R1: After reset, `busy`, `match`, `crcError`, `recordNotFound` and `dataValid` are all 0.
- R2: The check value is CRC-16 with polynomial 0x1021, shifted MSB first. It is preset to 0xFFFF before three 0xA1 syncs and the 0xFE mark. The record is good only if the register is zero after all six bytes. Corrupting any record byte, the data bytes included, is therefore detected.
- R3: In seek mode a record matches when byte 0 equals `trackReg`, byte 2 equals `sectorReg` and the CRC is good. Once the sixth byte has been accepted at a clock edge, the next edge sets `match`=1 and clears `busy`.
- R4: With `sideCmpEn`=1, byte 1 must also equal `sideSel` zero-extended to 8 bits. With `sideCmpEn`=0, byte 1 is ignored.
- R5: On a match, `sizeCode` equals byte 3 bits [1:0], and `sizeBytes` equals 128 shifted left by `sizeCode` (128, 256, 512 or 1024).
- R6: A record that matches but has a bad CRC sets `crcError`=1 and the search continues without `match`. A later good match clears `crcError`. A record that does not match leaves `crcError` unchanged, whatever its CRC.
- R7: If `INDEX_LIMIT` index pulses arrive while `busy`=1, the edge of the last pulse clears `busy` and sets `recordNotFound`=1. Any `crcError` from the search is kept. Fewer pulses leave the search running.
- R8: In read-address mode, each accepted record byte appears on `dataOut` with `dataValid`=1 one cycle later. After the sixth byte the search ends with `match`=0 and `recordNotFound`=0, and with `crcError`=1 exactly when the CRC is bad.
- R9: Stream bytes, marks and index pulses while idle have no effect. Bytes arriving during a search before a mark are not part of any record.
- R10: A start strobe while idle clears `match`, `crcError` and `recordNotFound` and sets `busy` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| searchStart | input | 1 | One-cycle strobe that begins a search |
| readAddr | input | 1 | Selects read-address mode; sampled at start |
| sideCmpEn | input | 1 | Enables the side comparison |
| sideSel | input | 1 | Expected side when the comparison is on |
| trackReg | input | 8 | Expected track number |
| sectorReg | input | 8 | Expected sector number |
| idMark | input | 1 | An ID address mark was just seen |
| byteValid | input | 1 | `byteIn` carries a stream byte |
| byteIn | input | 8 | Deserialised stream byte |
| indexPulse | input | 1 | One-cycle pulse per index hole |
| busy | output | 1 | Search in progress |
| match | output | 1 | Search ended on a good matching record |
| crcError | output | 1 | A relevant record had a bad CRC |
| recordNotFound | output | 1 | Search ended by the index timeout |
| sizeCode | output | 2 | Length code of the last record |
| sizeBytes | output | 11 | Data length in bytes decoded from `sizeCode` |
| dataOut | output | 8 | Record byte in read-address mode |
| dataValid | output | 1 | `dataOut` is valid |

## Verification
The bench builds the block with `INDEX_LIMIT`=3, so every no-match case ends within a few pulses. A full sweep of all four length codes, both compare settings, both expected sides, both record sides and three kinds of track/sector agreement therefore finishes quickly. Each case ends either in a match with the expected decoded length or in a timeout. Check bytes are generated in the bench by its own bitwise CRC. Single-byte corruption then reaches the error path in both modes.

// File: rtl/idchk_pkg.sv
package idchk_pkg;
  localparam int SIZE_W = 11;
  localparam int BASE_BYTES = 128;
  localparam logic [7:0] SYNC_BYTE = 8'hA1;
  localparam logic [7:0] MARK_BYTE = 8'hFE;

  typedef struct packed {
    logic arm;   // restart the record capture
    logic take;  // accept one record byte
  } dpStrobe_t;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [15:0] crcAfterMark();
    logic [15:0] r;
    r = 16'hFFFF;
    for (int k = 0; k < 3; k++) r = crcStep(r, SYNC_BYTE);
    return crcStep(r, MARK_BYTE);
  endfunction
endpackage

// File: rtl/idFieldPath.sv
module idFieldPath
  import idchk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              raMode,
  input  logic [7:0]        byteIn,
  input  logic [7:0]        trackReg,
  input  logic [7:0]        sectorReg,
  input  logic              sideCmpEn,
  input  logic              sideSel,
  output logic              lastByte,
  output logic              crcGood,
  output logic              idHit,
  output logic [1:0]        sizeCode,
  output logic [SIZE_W-1:0] sizeBytes,
  output logic [7:0]        dataOut,
  output logic              dataValid
);
  localparam logic [15:0] PRESET = crcAfterMark();
  localparam int REC_BYTES = 6;

  logic [15:0] crcReg;
  logic [2:0]  byteCnt;
  logic [7:0]  trkFld, sideFld, secFld;
  logic [1:0]  lenFld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= 16'hFFFF;
      byteCnt   <= '0;
      trkFld    <= '0;
      sideFld   <= '0;
      secFld    <= '0;
      lenFld    <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strobe.take && raMode;
      if (strobe.arm) begin
        crcReg  <= PRESET;
        byteCnt <= '0;
      end else if (strobe.take) begin
        crcReg  <= crcStep(crcReg, byteIn);
        byteCnt <= byteCnt + 3'd1;
        dataOut <= byteIn;
        case (byteCnt)
          3'd0: trkFld  <= byteIn;
          3'd1: sideFld <= byteIn;
          3'd2: secFld  <= byteIn;
          3'd3: lenFld  <= byteIn[1:0];
          default: ;
        endcase
      end
    end
  end

  assign lastByte  = byteCnt == 3'(REC_BYTES - 1);
  assign crcGood   = crcReg == 16'h0000;
  assign idHit     = (trkFld == trackReg) && (secFld == sectorReg) &&
                     (!sideCmpEn || sideFld == {7'b0, sideSel});
  assign sizeCode  = lenFld;
  assign sizeBytes = SIZE_W'(BASE_BYTES) << lenFld;
endmodule

// File: rtl/idSearchCtrl.sv
module idSearchCtrl
  import idchk_pkg::*;
#(
  parameter int INDEX_LIMIT = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      searchStart,
  input  logic      readAddr,
  input  logic      idMark,
  input  logic      byteValid,
  input  logic      indexPulse,
  input  logic      lastByte,
  input  logic      crcGood,
  input  logic      idHit,
  output dpStrobe_t strobe,
  output logic      raMode,
  output logic      busy,
  output logic      match,
  output logic      crcError,
  output logic      recordNotFound
);
  localparam int IDX_W = $clog2(INDEX_LIMIT + 1);

  typedef enum logic [1:0] {IDLE, SEARCH, CAPTURE, CHECK} state_t;
  state_t state;
  logic [IDX_W-1:0] idxCnt;
  logic finishNow, timeoutHit;

  always_comb begin
    strobe.arm  = (state == SEARCH || state == CAPTURE) && idMark;
    strobe.take = (state == CAPTURE) && byteValid && !idMark;
    finishNow   = (state == CHECK) && (raMode || (idHit && crcGood));
    timeoutHit  = (state != IDLE) && indexPulse && (idxCnt == IDX_W'(INDEX_LIMIT - 1));
  end

  assign busy = state != IDLE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state          <= IDLE;
      idxCnt         <= '0;
      raMode         <= 1'b0;
      match          <= 1'b0;
      crcError       <= 1'b0;
      recordNotFound <= 1'b0;
    end else if (state == IDLE) begin
      if (searchStart) begin
        state          <= SEARCH;
        idxCnt         <= '0;
        raMode         <= readAddr;
        match          <= 1'b0;
        crcError       <= 1'b0;
        recordNotFound <= 1'b0;
      end
    end else begin
      if (indexPulse) idxCnt <= idxCnt + 1'b1;
      case (state)
        SEARCH:  if (idMark) state <= CAPTURE;
        CAPTURE: if (!idMark && byteValid && lastByte) state <= CHECK;
        CHECK: begin
          if (raMode) begin
            crcError <= !crcGood;
            state    <= IDLE;
          end else if (idHit && crcGood) begin
            match    <= 1'b1;
            crcError <= 1'b0;
            state    <= IDLE;
          end else begin
            if (idHit) crcError <= 1'b1;
            state <= SEARCH;
          end
        end
        default: state <= IDLE;
      endcase
      if (timeoutHit && !finishNow) begin
        state          <= IDLE;
        recordNotFound <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/idFieldChecker.sv
module idFieldChecker
  import idchk_pkg::*;
#(
  parameter int INDEX_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              searchStart,
  input  logic              readAddr,
  input  logic              sideCmpEn,
  input  logic              sideSel,
  input  logic [7:0]        trackReg,
  input  logic [7:0]        sectorReg,
  input  logic              idMark,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  input  logic              indexPulse,
  output logic              busy,
  output logic              match,
  output logic              crcError,
  output logic              recordNotFound,
  output logic [1:0]        sizeCode,
  output logic [SIZE_W-1:0] sizeBytes,
  output logic [7:0]        dataOut,
  output logic              dataValid
);
  dpStrobe_t strobe;
  logic raMode, lastByte, crcGood, idHit;

  idSearchCtrl #(.INDEX_LIMIT(INDEX_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .searchStart(searchStart), .readAddr(readAddr),
    .idMark(idMark), .byteValid(byteValid), .indexPulse(indexPulse),
    .lastByte(lastByte), .crcGood(crcGood), .idHit(idHit),
    .strobe(strobe), .raMode(raMode), .busy(busy), .match(match),
    .crcError(crcError), .recordNotFound(recordNotFound)
  );

  idFieldPath u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .raMode(raMode), .byteIn(byteIn),
    .trackReg(trackReg), .sectorReg(sectorReg), .sideCmpEn(sideCmpEn),
    .sideSel(sideSel), .lastByte(lastByte), .crcGood(crcGood), .idHit(idHit),
    .sizeCode(sizeCode), .sizeBytes(sizeBytes), .dataOut(dataOut),
    .dataValid(dataValid)
  );
endmodule

// File: rtl/idFieldChecker_chk.sv
module idFieldChecker_chk (
  input logic clk,
  input logic rstN,
  input logic searchStart,
  input logic busy,
  input logic match,
  input logic crcError,
  input logic recordNotFound,
  input logic dataValid
);
  AST_MATCH_NOT_RNF: assert property (@(posedge clk) disable iff (!rstN)
    !(match && recordNotFound)); // R3
  AST_MATCH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    match |-> !busy); // R3
  AST_MATCH_FROM_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(match) |-> $past(busy)); // R3
  AST_RNF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    recordNotFound |-> !busy); // R7
  AST_DV_IN_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> $past(busy)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !searchStart) |=> (!busy && $stable(match) && $stable(recordNotFound))); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && searchStart) |=> (busy && !match && !crcError && !recordNotFound)); // R10
endmodule

bind idFieldChecker idFieldChecker_chk u_chk (
  .clk(clk), .rstN(rstN), .searchStart(searchStart), .busy(busy), .match(match),
  .crcError(crcError), .recordNotFound(recordNotFound), .dataValid(dataValid)
);

// File: tb/idFieldChecker_tb.sv
module idFieldChecker_tb;
  localparam int LIMIT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic searchStart = 0, readAddr = 0, sideCmpEn = 0, sideSel = 0;
  logic [7:0] trackReg = 0, sectorReg = 0, byteIn = 0;
  logic idMark = 0, byteValid = 0, indexPulse = 0;
  logic busy, match, crcError, recordNotFound, dataValid;
  logic [1:0] sizeCode;
  logic [10:0] sizeBytes;
  logic [7:0] dataOut;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  idFieldChecker #(.INDEX_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .searchStart(searchStart), .readAddr(readAddr),
    .sideCmpEn(sideCmpEn), .sideSel(sideSel), .trackReg(trackReg),
    .sectorReg(sectorReg), .idMark(idMark), .byteValid(byteValid),
    .byteIn(byteIn), .indexPulse(indexPulse), .busy(busy), .match(match),
    .crcError(crcError), .recordNotFound(recordNotFound), .sizeCode(sizeCode),
    .sizeBytes(sizeBytes), .dataOut(dataOut), .dataValid(dataValid)
  );

  function automatic logic [15:0] tbCrc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 0; b < 8; b++) begin
      logic top = r[15] ^ d[7-b];
      r = r << 1;
      if (top) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic startSearch(input logic ra);
    @(negedge clk); searchStart = 1; readAddr = ra;
    @(negedge clk); searchStart = 0;
  endtask

  task automatic pulseIndex();
    @(negedge clk); indexPulse = 1;
    @(negedge clk); indexPulse = 0;
  endtask

  // mark, then six record bytes; returns one cycle after the result edge
  task automatic sendField(input logic [7:0] t, input logic [7:0] s, input logic [7:0] sec,
                           input logic [7:0] len, input logic [15:0] crcFlip,
                           input logic [7:0] dataFlip, input logic raChk);
    logic [7:0] rec [6];
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < 3; k++) c = tbCrc(c, 8'hA1);
    c = tbCrc(c, 8'hFE);
    rec[0] = t; rec[1] = s; rec[2] = sec; rec[3] = len;
    for (int k = 0; k < 4; k++) c = tbCrc(c, rec[k]);
    c = c ^ crcFlip;
    rec[4] = c[15:8]; rec[5] = c[7:0];
    rec[0] = rec[0] ^ dataFlip;
    @(negedge clk); idMark = 1;
    @(negedge clk); idMark = 0;
    for (int k = 0; k < 6; k++) begin
      byteValid = 1; byteIn = rec[k];
      @(negedge clk);
      if (raChk) begin
        chk("R8 dataValid", 32'(dataValid), 32'd1);
        chk("R8 dataOut", 32'(dataOut), 32'(rec[k]));
      end
    end
    byteValid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 match", 32'(match), 0);
    chk("R1 crcError", 32'(crcError), 0);
    chk("R1 recordNotFound", 32'(recordNotFound), 0);
    chk("R1 dataValid", 32'(dataValid), 0);
    rstN = 1;

    // R9: idle traffic has no effect
    readAddr = 1;
    sendField(8'd1, 8'd0, 8'd1, 8'd1, 16'h0, 8'h0, 1'b0);
    pulseIndex(); pulseIndex(); pulseIndex();
    chk("R9 idle busy", 32'(busy), 0);
    chk("R9 idle dataValid", 32'(dataValid), 0);
    chk("R9 idle rnf", 32'(recordNotFound), 0);
    readAddr = 0;

    // sweep: length code, compare enable, expected side, record side, mismatch kind
    for (int code = 0; code < 4; code++)
      for (int sc = 0; sc < 2; sc++)
        for (int ss = 0; ss < 2; ss++)
          for (int fs = 0; fs < 2; fs++)
            for (int kind = 0; kind < 3; kind++) begin
              logic [7:0] ft, fsec;
              logic expHit;
              trackReg  = 8'(code * 17 + 3);
              sectorReg = 8'(sc * 5 + ss * 2 + fs + 1);
              sideCmpEn = sc[0]; sideSel = ss[0];
              ft   = (kind == 1) ? trackReg ^ 8'h40 : trackReg;
              fsec = (kind == 2) ? sectorReg + 8'd1 : sectorReg;
              expHit = (kind == 0) && (!sc[0] || fs == ss);
              startSearch(1'b0);
              sendField(ft, 8'(fs), fsec, {6'b101100, 2'(code)}, 16'h0, 8'h0, 1'b0);
              if (expHit) begin
                chk("R3 match", 32'(match), 1);
                chk("R3 busy ends", 32'(busy), 0);
                chk("R5 sizeCode", 32'(sizeCode), 32'(code));
                chk("R5 sizeBytes", 32'(sizeBytes), 32'(128 << code));
                chk("R4 side rule hit", 32'(recordNotFound), 0);
              end else begin
                chk("R4 no match yet", 32'(match), 0);
                chk("R3 still busy", 32'(busy), 1);
                for (int p = 0; p < LIMIT - 1; p++) pulseIndex();
                chk("R7 before limit", 32'(busy), 1);
                pulseIndex();
                chk("R7 timeout busy", 32'(busy), 0);
                chk("R7 timeout rnf", 32'(recordNotFound), 1);
                chk("R6 clean crc", 32'(crcError), 0);
              end
            end

    // R6 bad CRC on matching record, then good match
    trackReg = 8'd40; sectorReg = 8'd9; sideCmpEn = 0;
    startSearch(1'b0);
    chk("R10 start clears", 32'(recordNotFound), 0);
    sendField(8'd40, 8'd0, 8'd9, 8'd2, 16'h0010, 8'h0, 1'b0);
    chk("R6 crcError set", 32'(crcError), 1);
    chk("R6 no match", 32'(match), 0);
    chk("R6 keeps searching", 32'(busy), 1);
    sendField(8'd41, 8'd0, 8'd9, 8'd2, 16'h0001, 8'h0, 1'b0);
    chk("R6 miss leaves crcError", 32'(crcError), 1);
    sendField(8'd40, 8'd0, 8'd9, 8'd2, 16'h0, 8'h0, 1'b0);
    chk("R6 later match", 32'(match), 1);
    chk("R6 match clears crcError", 32'(crcError), 0);

    // R6/R7 bad CRC then timeout keeps crcError
    startSearch(1'b0);
    chk("R10 start clears match", 32'(match), 0);
    sendField(8'd40, 8'd0, 8'd9, 8'd2, 16'h8000, 8'h0, 1'b0);
    for (int p = 0; p < LIMIT; p++) pulseIndex();
    chk("R7 rnf with crc", 32'(recordNotFound), 1);
    chk("R7 crcError kept", 32'(crcError), 1);

    // R6 bad CRC on non-matching record ignored
    startSearch(1'b0);
    sendField(8'd7, 8'd0, 8'd9, 8'd2, 16'h0100, 8'h0, 1'b0);
    chk("R6 miss bad crc ignored", 32'(crcError), 0);
    for (int p = 0; p < LIMIT; p++) pulseIndex();

    // R9 stray bytes before a mark
    startSearch(1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); byteValid = 1; byteIn = 8'(k + 40);
    end
    @(negedge clk); byteValid = 0;
    sendField(8'd40, 8'd1, 8'd9, 8'd3, 16'h0, 8'h0, 1'b0);
    chk("R9 stray bytes ignored", 32'(match), 1);
    chk("R9 size after stray", 32'(sizeBytes), 1024);

    // R8 read-address, good and corrupted
    startSearch(1'b1);
    sendField(8'd77, 8'd1, 8'd200, 8'd0, 16'h0, 8'h0, 1'b1);
    chk("R8 ends", 32'(busy), 0);
    chk("R8 no match", 32'(match), 0);
    chk("R8 no rnf", 32'(recordNotFound), 0);
    chk("R8 crc good", 32'(crcError), 0);
    startSearch(1'b1);
    sendField(8'd77, 8'd1, 8'd200, 8'd0, 16'h0, 8'h04, 1'b1);
    chk("R2 data byte corruption", 32'(crcError), 1);
    startSearch(1'b1);
    for (int p = 0; p < LIMIT; p++) pulseIndex();
    chk("R7 ra timeout", 32'(recordNotFound), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule